// File: doc/BRIEF.md
# MDIO Management Master with Register Front End

This block runs management frames on an MDC/MDIO pair for a PHY or other station. Software sets up a transaction through four registers on a simple single-cycle bus: a 16-bit data word, a 16-bit extended register address and a 13-bit operation word. It then writes 1 to a control register. That control register reads 1 while the frame is on the wire and 0 once the frame has finished. When a read finishes, the data word holds the 16 bits that the station returned.

The operation word chooses between the two management clause families. The same two-bit code field serves both families. For an extended-clause (Clause 45) access, software launches twice: first an address cycle, which carries the address register, and then the data cycle. MDC comes from the system clock through a half-period divider parameter. The clock runs only while a frame is in flight.

Top module: `mdio_master`

## Requirements
- R1: After reset, all four registers read 0, mdc_o is low and mdio_oe_o is low.
- R2: The register offsets are as follows. 0x10 is the data word, in bits 15:0. 0x14 is the extended address, in bits 15:0. 0x18 is the operation word, in bits 12:0. 0x1C is control, whose bit 0 reads back busy. The data, address and operation registers read back what was written to them.
- R3: Every frame is 64 bits, sent MSB first, in this order: 32 ones, a start code, the 2-bit op code, the 5-bit port address, the 5-bit device/register address, 2 turnaround bits and 16 data bits. The start code is 00 when operation bit 12 is 1 (Clause 45) and 01 when it is 0. Bits 11:10 hold the op code, bits 9:5 the port and bits 4:0 the device/register.
- R4: When op bit 1 is 0 (Clause 22 write 01, Clause 45 address 00 or write 01), the master drives all 64 bits. The turnaround is 10. The data field is the address register for a Clause 45 op 00 and the data register otherwise.
- R5: When op bit 1 is 1 (Clause 22 read 10, Clause 45 read 11), the master stops driving at the first turnaround bit and keeps MDIO released through bit 63. It samples the 16 data bits on rising MDC. When busy clears, the data register holds those bits.
- R6: Writing a value with bit 0 set to 0x1C while idle starts a frame, and busy reads 1 until the frame ends. A write to 0x1C with bit 0 clear starts nothing.
- R7: A write to 0x1C while busy is ignored. The frame in flight and the time at which it ends are unchanged.
- R8: While idle, mdio_oe_o is low and mdc_o is low.
- R9: Each MDC phase lasts CLK_HALF system cycles. Busy stays high for exactly 128*CLK_HALF cycles after the go write.

Top module ports are below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_req_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write enable for the access |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The bench drives all five op codes across both clause families and compares every transmitted bit against a frame it builds itself. A wrong start code, a swapped field or a wrong data source for the Clause 45 address cycle would each show up as a bit mismatch. On reads, the responder drives the second turnaround bit low and then the data. A master that released MDIO late would collide with the station, and the enabled-bit count would be wrong. A master that sampled on the wrong edge would capture shifted data. A go write issued mid-frame must leave both the frame and the busy length untouched; a design that restarted would stretch busy past 128*CLK_HALF cycles.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam logic [7:0] OFS_DATA = 8'h10;
  localparam logic [7:0] OFS_ADDR = 8'h14;
  localparam logic [7:0] OFS_OP   = 8'h18;
  localparam logic [7:0] OFS_CTRL = 8'h1C;

  localparam int FRAME_LEN = 64;
  localparam int TA_POS    = 46;
  localparam int DATA_POS  = 48;

  typedef struct packed {
    logic       c45;
    logic [1:0] code;
    logic [4:0] port;
    logic [4:0] dev;
  } op_word_t;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int CLK_HALF = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          wrap;

  assign wrap   = en_i && (cnt_q == LAST);
  assign rise_o = wrap && !mdc_q;
  assign fall_o = wrap && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= !mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        go_i,
  input  op_word_t    op_i,
  input  logic [15:0] data_i,
  input  logic [15:0] addr_i,
  input  logic        rise_i,
  input  logic        fall_i,
  input  logic        mdio_i,
  output logic        busy_o,
  output logic [5:0]  bit_cnt_o,
  output logic        rd_o,
  output logic        done_o,
  output logic        cap_o,
  output logic [15:0] rd_data_o,
  output logic        mdio_o,
  output logic        oe_o
);
  localparam logic [5:0] LAST_BIT = 6'(FRAME_LEN - 1);
  localparam logic [5:0] TA_BIT   = 6'(TA_POS);
  localparam logic [5:0] DAT_BIT  = 6'(DATA_POS);

  logic [FRAME_LEN-1:0] sh_q;
  logic [5:0]           cnt_q;
  logic                 busy_q, rd_q;
  logic [15:0]          rsh_q;
  logic [1:0]           start_code;
  logic [15:0]          field;

  assign start_code = op_i.c45 ? 2'b00 : 2'b01;
  // address cycle carries the extended address, everything else the data word
  assign field = (op_i.c45 && op_i.code == 2'b00) ? addr_i : data_i;

  assign done_o    = busy_q && fall_i && (cnt_q == LAST_BIT);
  assign cap_o     = done_o && rd_q;
  assign busy_o    = busy_q;
  assign bit_cnt_o = cnt_q;
  assign rd_o      = rd_q;
  assign rd_data_o = rsh_q;
  assign mdio_o    = sh_q[FRAME_LEN-1];
  assign oe_o      = busy_q && !(rd_q && cnt_q >= TA_BIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      rsh_q  <= '0;
    end else if (!busy_q) begin
      if (go_i) begin
        sh_q   <= {32'hFFFF_FFFF, start_code, op_i.code, op_i.port, op_i.dev,
                   2'b10, field};
        cnt_q  <= '0;
        busy_q <= 1'b1;
        rd_q   <= op_i.code[1];
      end
    end else begin
      if (rise_i && rd_q && cnt_q >= DAT_BIT)
        rsh_q <= {rsh_q[14:0], mdio_i};
      if (fall_i) begin
        if (cnt_q == LAST_BIT) begin
          busy_q <= 1'b0;
          sh_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
          sh_q  <= {sh_q[FRAME_LEN-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  input  logic          busy_i,
  input  logic          cap_i,
  input  logic [15:0]   rd_data_i,
  output logic          go_o,
  output logic [15:0]   data_o,
  output logic [15:0]   xaddr_o,
  output op_word_t      op_o
);
  logic [15:0] data_q, xaddr_q;
  op_word_t    op_q;
  logic        wr;

  assign wr   = req_i && we_i;
  assign go_o = wr && (addr_i == AW'(OFS_CTRL)) && wdata_i[0] && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      xaddr_q <= '0;
      op_q    <= '0;
    end else begin
      if (cap_i)
        data_q <= rd_data_i;
      else if (wr && addr_i == AW'(OFS_DATA))
        data_q <= wdata_i[15:0];
      if (wr && addr_i == AW'(OFS_ADDR)) xaddr_q <= wdata_i[15:0];
      if (wr && addr_i == AW'(OFS_OP))   op_q    <= op_word_t'(wdata_i[12:0]);
    end
  end

  always_comb begin
    rdata_o = '0;
    if      (addr_i == AW'(OFS_DATA)) rdata_o[15:0] = data_q;
    else if (addr_i == AW'(OFS_ADDR)) rdata_o[15:0] = xaddr_q;
    else if (addr_i == AW'(OFS_OP))   rdata_o[12:0] = op_q;
    else if (addr_i == AW'(OFS_CTRL)) rdata_o[0]    = busy_i;
  end

  assign data_o  = data_q;
  assign xaddr_o = xaddr_q;
  assign op_o    = op_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int CLK_HALF = 40,
  parameter int AW       = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_req_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [31:0]   bus_wdata_i,
  output logic [31:0]   bus_rdata_o,
  output logic          mdc_o,
  output logic          mdio_o,
  output logic          mdio_oe_o,
  input  logic          mdio_i
);
  logic        go, busy, rise, fall, done, cap, frame_rd;
  logic [5:0]  bit_cnt;
  logic [15:0] data_w, xaddr_w, rd_data;
  op_word_t    op_w;

  mdio_regs #(.AW(AW)) u_regs (
    .clk_i, .rst_ni,
    .req_i(bus_req_i), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
    .busy_i(busy), .cap_i(cap), .rd_data_i(rd_data),
    .go_o(go), .data_o(data_w), .xaddr_o(xaddr_w), .op_o(op_w)
  );

  mdio_clkgen #(.CLK_HALF(CLK_HALF)) u_clk (
    .clk_i, .rst_ni, .en_i(busy),
    .mdc_o(mdc_o), .rise_o(rise), .fall_o(fall)
  );

  mdio_frame u_frame (
    .clk_i, .rst_ni, .go_i(go), .op_i(op_w), .data_i(data_w), .addr_i(xaddr_w),
    .rise_i(rise), .fall_i(fall), .mdio_i(mdio_i),
    .busy_o(busy), .bit_cnt_o(bit_cnt), .rd_o(frame_rd), .done_o(done),
    .cap_o(cap), .rd_data_o(rd_data), .mdio_o(mdio_o), .oe_o(mdio_oe_o)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_i,
  input logic       done_i,
  input logic       rd_i,
  input logic [5:0] bit_cnt_i,
  input logic       mdc_i,
  input logic       mdio_i,
  input logic       oe_i
);
  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (!oe_i && !mdc_i));

  p_preamble_ones_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && bit_cnt_i < 6'd32) |-> (oe_i && mdio_i));

  p_read_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && rd_i && bit_cnt_i >= 6'd46) |-> !oe_i);

  p_write_drives_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !rd_i) |-> oe_i);

  p_busy_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !done_i) |=> busy_i);

  p_no_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !done_i) |=> (bit_cnt_i >= $past(bit_cnt_i) && rd_i == $past(rd_i)));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy), .done_i(done), .rd_i(frame_rd),
  .bit_cnt_i(bit_cnt), .mdc_i(mdc_o), .mdio_i(mdio_o), .oe_i(mdio_oe_o)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  localparam int HALF = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mdc, mdio_o, oe;
  logic        mdio_in = 1'b1;

  int n_chk = 0, n_fail = 0;

  typedef struct {
    logic [63:0] bits;
    int          oe_n;
    string       tag;
  } item_t;
  item_t exp_q[$];

  logic        cur_rd = 1'b0;
  logic [15:0] cur_rdval = '0;
  int          mon_idx = 0, mon_oe = 0;
  logic [63:0] mon_bits = '0;
  logic        mdc_prev = 1'b0;

  always #2.5 clk = ~clk;

  mdio_master #(.CLK_HALF(HALF)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .mdc_o(mdc), .mdio_o(mdio_o), .mdio_oe_o(oe), .mdio_i(mdio_in)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic resp_bit(input int idx);
    if (!cur_rd) return 1'b1;
    if (idx == 47) return 1'b0;
    if (idx >= 48) return cur_rdval[63-idx];
    return 1'b1;
  endfunction

  // monitor + responder: sample the line on each MDC rise, compare whole frames
  always @(negedge clk) begin
    if (mdc && !mdc_prev) begin
      mon_bits = {mon_bits[62:0], (oe ? mdio_o : mdio_in)};
      if (oe) mon_oe++;
      mon_idx++;
      if (mon_idx == 64) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected frame", mon_bits, '0);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          check(mon_bits == e.bits, e.tag, mon_bits, e.bits);
          check(mon_oe == e.oe_n, {e.tag, " drive count"}, 64'(mon_oe), 64'(e.oe_n));
        end
        mon_idx = 0;
        mon_oe  = 0;
      end
    end
    mdc_prev = mdc;
    mdio_in  = resp_bit(mon_idx);
  end

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; #1;
    d = rdata;
  endtask

  // driver: program, push expected frame, launch, time busy
  task automatic xact(input logic [12:0] op, input logic [15:0] xa,
                      input logic [15:0] dat, input logic [15:0] rv,
                      input bit dbl_go, input string tag);
    item_t e;
    logic [15:0] field;
    logic [31:0] r;
    int cnt;
    bit rd;
    rd = op[11];
    field = rd ? rv : ((op[12] && op[11:10] == 2'b00) ? xa : dat);
    e.bits = {32'hFFFF_FFFF, (op[12] ? 2'b00 : 2'b01), op[11:0], 2'b10, field};
    e.oe_n = rd ? 46 : 64;
    e.tag  = tag;
    bus_wr(8'h14, {16'h0, xa});
    bus_wr(8'h10, {16'h0, dat});
    bus_wr(8'h18, {19'h0, op});
    exp_q.push_back(e);
    cur_rd = rd;
    cur_rdval = rv;
    bus_wr(8'h1C, 32'h1);
    cnt = 0;
    addr = 8'h1C;
    #1;
    while (rdata[0] && cnt < 100000) begin
      cnt++;
      @(negedge clk);
      if (dbl_go && cnt == 50) begin
        req = 1'b1; we = 1'b1; wdata = 32'h1;
      end else begin
        req = 1'b0; we = 1'b0;
      end
      #1;
    end
    req = 1'b0; we = 1'b0;
    check(cnt == 128*HALF, dbl_go ? "R7 busy length with extra go" : "R9 busy length",
          64'(cnt), 64'(128*HALF));
    @(negedge clk);
    check(!oe && !mdc, "R8 idle after frame", {62'h0, oe, mdc}, 64'h0);
    if (rd) begin
      bus_rd(8'h10, r);
      check(r == {16'h0, rv}, "R5 read data captured", 64'(r), 64'(rv));
    end
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(!mdc && !oe, "R1 pins after reset", {62'h0, mdc, oe}, 64'h0);
    bus_rd(8'h10, r); check(r == 0, "R1 data reg", 64'(r), 64'h0);
    bus_rd(8'h14, r); check(r == 0, "R1 addr reg", 64'(r), 64'h0);
    bus_rd(8'h18, r); check(r == 0, "R1 op reg", 64'(r), 64'h0);
    bus_rd(8'h1C, r); check(r == 0, "R1 ctrl reg", 64'(r), 64'h0);
    // R2 readback
    bus_wr(8'h10, 32'hFFFF_A5C3); bus_rd(8'h10, r);
    check(r == 32'h0000_A5C3, "R2 data readback", 64'(r), 64'hA5C3);
    bus_wr(8'h14, 32'h0000_1234); bus_rd(8'h14, r);
    check(r == 32'h0000_1234, "R2 addr readback", 64'(r), 64'h1234);
    bus_wr(8'h18, 32'hFFFF_FABC); bus_rd(8'h18, r);
    check(r == 32'h0000_1ABC, "R2 op readback", 64'(r), 64'h1ABC);
    // R6 go with bit 0 clear does nothing
    bus_wr(8'h1C, 32'h2); bus_rd(8'h1C, r);
    check(r == 0 && !oe, "R6 go bit clear ignored", 64'(r), 64'h0);

    xact({1'b0, 2'b01, 5'd3, 5'd9}, 16'h0000, 16'hBEEF, 16'h0, 1'b0, "R3 R4 clause22 write");
    xact({1'b0, 2'b10, 5'd3, 5'd1}, 16'h0000, 16'h0000, 16'h796D, 1'b0, "R3 R5 clause22 read");
    xact({1'b1, 2'b00, 5'd7, 5'd1}, 16'h0A0B, 16'h5555, 16'h0, 1'b0, "R4 clause45 address");
    xact({1'b1, 2'b01, 5'd7, 5'd1}, 16'h0A0B, 16'h1357, 16'h0, 1'b0, "R4 clause45 write");
    xact({1'b1, 2'b00, 5'd30, 5'd31}, 16'hF00D, 16'h0, 16'h0, 1'b0, "R4 clause45 address pre-read");
    xact({1'b1, 2'b11, 5'd30, 5'd31}, 16'hF00D, 16'h0, 16'hC0DE, 1'b1, "R7 R5 clause45 read with extra go");

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R3 all frames seen", 64'(exp_q.size()), 64'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #900us;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule